// File: doc/BRIEF.md
# Bit-Masked PHY Control Register Bank

This block holds the configuration of a storage-interface PHY in a small bank of 32-bit registers on a simple valid/ready register bus. Every write carries its own enable mask in its upper half-word. Data bit `x+16` decides whether stored bit `x` takes the new value from the lower half-word. Software can therefore change one field, such as the DLL enable, with a single write, and the fields around it keep their values with no read-modify-write.

The bank has seven control registers at byte offsets 0x00 to 0x18, in steps of four. It also has one read-only status register at 0x20. The PHY-facing fields are decoded from the stored bits and driven out continuously. A read of the status register returns the calibration-done and DLL-ready inputs as they are on the cycle the read is accepted. The bus accepts one request per cycle and answers each one exactly one cycle later.

Top module: `phy_ctl_regbank`

## Requirements
- R1: During and after reset, every control bit is 0 except the tap-delay select (register 0x00, bits 10:7), which is 4. A first read of 0x00 therefore returns 0x00000200.
- R2: On an accepted write to a control register, stored bit x (0..15) takes data bit x only when data bit x+16 is 1. Every other stored bit keeps its value.
- R3: A write whose upper 16 data bits are all zero leaves the addressed register unchanged.
- R4: A read of a control register returns the stored 16 bits in rdata[15:0]. rdata[31:16] is zero on every response.
- R5: Register 0x18 drives `pwr_on` from bit 0 (1 = powered), `dll_en` from bit 1 and `drv_code` from bits 6:4. The drive codes are 0 = 50 Ω, 1 = 33 Ω, 2 = 66 Ω, 3 = 100 Ω and 4 = 40 Ω.
- R6: Register 0x00 drives `dll_freq` from bits 13:12 (0 = 200 MHz, 1 = 50 MHz, 2 = 100 MHz, 3 = 150 MHz), `tap_en` from bit 11 and `tap_sel` from bits 10:7.
- R7: Register 0x08 drives `strobe_pd` from bit 9.
- R8: A read of 0x20 returns `cal_done` in bit 6 and `dll_ready` in bit 5, both sampled on the cycle the read is accepted. All other bits are zero.
- R9: A write to 0x20 changes no control output and no stored control bit.
- R10: An access to any other offset is unmapped, including an offset that is not a multiple of four. An unmapped read returns zero. An unmapped write changes nothing.
- R11: `req_ready` is always 1. `rsp_valid` is high exactly on the cycle after each accepted request. A write response carries rdata zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | DATA_W | Write data: mask in upper half, value in lower half |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | DATA_W | Read data |
| cal_done | input | 1 | PHY calibration done status |
| dll_ready | input | 1 | PHY DLL lock status |
| pwr_on | output | 1 | PHY power-down-bar (1 = powered) |
| dll_en | output | 1 | DLL enable |
| drv_code | output | 3 | Output drive-strength code |
| dll_freq | output | 2 | DLL frequency range select |
| tap_en | output | 1 | Output tap delay enable |
| tap_sel | output | 4 | Output tap delay select |
| strobe_pd | output | 1 | Strobe-line pull-down enable |

## Verification
Masked writes are tried with four mask shapes:
- A mask over a whole field, which shows that the field decodes to the right output.
- A single-bit mask with an all-ones value, which shows that neighbouring bits in the same register are protected.
- An all-zero mask with an all-ones value, which separates a real mask from a plain store.
- A full mask, which confirms that all sixteen bits can be written.

Status reads are tried with each of the two flags alone and then both together, so that a swapped or stuck bit shows up. Writes to the status offset, to a gap offset and to a misaligned offset are each followed by readback of every output. This tells a decoder that aliases addresses apart from one that rejects them.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;
   // Register indices (byte offset / 4) whose fields the PHY decodes
   localparam int MAIN_REG = 0;
   localparam int PAD_REG  = 2;
   localparam int PWR_REG  = 6;

   // Field positions inside the 16-bit stored half-word
   localparam int PWR_BIT     = 0;
   localparam int DLLEN_BIT   = 1;
   localparam int DRV_LSB     = 4;
   localparam int TAPSEL_LSB  = 7;
   localparam int TAPEN_BIT   = 11;
   localparam int FREQ_LSB    = 12;
   localparam int STRB_BIT    = 9;

   // Status bit positions
   localparam int CAL_BIT     = 6;
   localparam int DLLRDY_BIT  = 5;

   typedef struct packed {
      logic       pwr_on;
      logic       dll_en;
      logic [2:0] drv_code;
      logic [1:0] dll_freq;
      logic       tap_en;
      logic [3:0] tap_sel;
      logic       strobe_pd;
   } phy_ctl_t;
endpackage

// File: rtl/masked_reg.sv
module masked_reg #(
   parameter int          HALF_W    = 16,
   parameter logic [15:0] RESET_VAL = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [2*HALF_W-1:0] wdata,
   output logic [HALF_W-1:0]   q
);
   logic [HALF_W-1:0] mask;
   logic [HALF_W-1:0] val;

   assign mask = wdata[2*HALF_W-1:HALF_W];
   assign val  = wdata[HALF_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RESET_VAL[HALF_W-1:0];
      else if (wr_en)
         q <= (q & ~mask) | (val & mask);
   end
endmodule

// File: rtl/reg_decode.sv
module reg_decode #(
   parameter int ADDR_W    = 8,
   parameter int NUM_CTRL  = 7,
   parameter int STAT_OFFS = 32
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_CTRL-1:0] ctl_sel,
   output logic                stat_sel
);
   genvar i;
   generate
      for (i = 0; i < NUM_CTRL; i++) begin : g_sel
         assign ctl_sel[i] = (addr == ADDR_W'(i * 4));
      end
   endgenerate

   assign stat_sel = (addr == ADDR_W'(STAT_OFFS));
endmodule

// File: rtl/read_mux.sv
module read_mux #(
   parameter int HALF_W   = 16,
   parameter int NUM_CTRL = 7
) (
   input  logic [NUM_CTRL-1:0][HALF_W-1:0] ctl_q,
   input  logic [NUM_CTRL-1:0]             ctl_sel,
   input  logic                            stat_sel,
   input  logic [HALF_W-1:0]               stat_word,
   output logic [2*HALF_W-1:0]             rdata
);
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CTRL; i++) begin
         if (ctl_sel[i])
            rdata[HALF_W-1:0] = ctl_q[i];
      end
      if (stat_sel)
         rdata[HALF_W-1:0] = stat_word;
   end
endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
   import phyreg_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int NUM_CTRL  = 7,
   parameter int STAT_OFFS = 32,
   parameter int TAP_RESET = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              cal_done,
   input  logic              dll_ready,
   output logic              pwr_on,
   output logic              dll_en,
   output logic [2:0]        drv_code,
   output logic [1:0]        dll_freq,
   output logic              tap_en,
   output logic [3:0]        tap_sel,
   output logic              strobe_pd
);
   localparam int HALF_W = DATA_W / 2;

   // Elaboration-time parameter checks
   generate
      if (DATA_W % 2 != 0 || HALF_W < FREQ_LSB + 2) begin : g_bad_width
         $error("DATA_W must be even and hold all fields");
      end
      if (NUM_CTRL <= PWR_REG) begin : g_bad_count
         $error("NUM_CTRL too small for the power register");
      end
      if (STAT_OFFS % 4 != 0 || STAT_OFFS < NUM_CTRL * 4) begin : g_bad_stat
         $error("STAT_OFFS must be aligned and above the control registers");
      end
      if (STAT_OFFS >= (1 << ADDR_W) || TAP_RESET > 15) begin : g_bad_range
         $error("STAT_OFFS or TAP_RESET out of range");
      end
   endgenerate

   logic [NUM_CTRL-1:0]             ctl_sel;
   logic                            stat_sel;
   logic [NUM_CTRL-1:0][HALF_W-1:0] ctl_q;
   logic [HALF_W-1:0]               stat_word;
   logic [DATA_W-1:0]               rd_mux;
   logic                            wr_acc;
   phy_ctl_t                        fields;

   assign req_ready = 1'b1;
   assign wr_acc    = req_valid & req_write;

   reg_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_CTRL (NUM_CTRL),
      .STAT_OFFS(STAT_OFFS)
   ) u_dec (
      .addr    (req_addr),
      .ctl_sel (ctl_sel),
      .stat_sel(stat_sel)
   );

   genvar i;
   generate
      for (i = 0; i < NUM_CTRL; i++) begin : g_reg
         localparam logic [15:0] RST =
            (i == MAIN_REG) ? 16'(TAP_RESET << TAPSEL_LSB) : 16'h0;
         masked_reg #(
            .HALF_W   (HALF_W),
            .RESET_VAL(RST)
         ) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(wr_acc & ctl_sel[i]),
            .wdata(req_wdata),
            .q    (ctl_q[i])
         );
      end
   endgenerate

   always_comb begin
      stat_word             = '0;
      stat_word[CAL_BIT]    = cal_done;
      stat_word[DLLRDY_BIT] = dll_ready;
   end

   read_mux #(
      .HALF_W  (HALF_W),
      .NUM_CTRL(NUM_CTRL)
   ) u_rmux (
      .ctl_q    (ctl_q),
      .ctl_sel  (ctl_sel),
      .stat_sel (stat_sel),
      .stat_word(stat_word),
      .rdata    (rd_mux)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
      end
   end

   // Field decode towards the PHY
   assign fields.pwr_on    = ctl_q[PWR_REG][PWR_BIT];
   assign fields.dll_en    = ctl_q[PWR_REG][DLLEN_BIT];
   assign fields.drv_code  = ctl_q[PWR_REG][DRV_LSB +: 3];
   assign fields.dll_freq  = ctl_q[MAIN_REG][FREQ_LSB +: 2];
   assign fields.tap_en    = ctl_q[MAIN_REG][TAPEN_BIT];
   assign fields.tap_sel   = ctl_q[MAIN_REG][TAPSEL_LSB +: 4];
   assign fields.strobe_pd = ctl_q[PAD_REG][STRB_BIT];

   assign pwr_on    = fields.pwr_on;
   assign dll_en    = fields.dll_en;
   assign drv_code  = fields.drv_code;
   assign dll_freq  = fields.dll_freq;
   assign tap_en    = fields.tap_en;
   assign tap_sel   = fields.tap_sel;
   assign strobe_pd = fields.strobe_pd;
endmodule

// File: rtl/phy_ctl_regbank_chk.sv
module phy_ctl_regbank_chk
   import phyreg_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int STAT_OFFS = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_wdata,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              cal_done,
   input logic              dll_ready,
   input logic              pwr_on,
   input logic              dll_en,
   input logic [2:0]        drv_code,
   input logic [1:0]        dll_freq,
   input logic              tap_en,
   input logic [3:0]        tap_sel,
   input logic              strobe_pd
);
   localparam int HALF_W = DATA_W / 2;
   localparam logic [ADDR_W-1:0] PWR_ADDR  = ADDR_W'(PWR_REG * 4);
   localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFFS);
   localparam logic [ADDR_W-1:0] GAP_ADDR  = ADDR_W'(STAT_OFFS + 4);

   logic [13:0] outs;
   assign outs = {pwr_on, dll_en, drv_code, dll_freq, tap_en, tap_sel, strobe_pd};

   // R11
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R11
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R4
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_rdata[DATA_W-1:HALF_W] == '0);
   // R2
   masked_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == PWR_ADDR && req_wdata[HALF_W + PWR_BIT])
      |=> pwr_on == $past(req_wdata[PWR_BIT]));
   // R3
   zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_wdata[DATA_W-1:HALF_W] == '0) |=> $stable(outs));
   // R9
   status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == STAT_ADDR) |=> $stable(outs));
   // R8
   status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == STAT_ADDR)
      |=> (rsp_rdata[CAL_BIT] == $past(cal_done) && rsp_rdata[DLLRDY_BIT] == $past(dll_ready)));
   // R10
   gap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == GAP_ADDR) |=> rsp_rdata == '0);
endmodule

bind phy_ctl_regbank phy_ctl_regbank_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .STAT_OFFS(STAT_OFFS)
) chk_i (.*);

// File: tb/phy_ctl_regbank_test.sv
module phy_ctl_regbank_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        cal_done = 1'b0;
   logic        dll_ready = 1'b0;
   logic        pwr_on, dll_en, tap_en, strobe_pd;
   logic [2:0]  drv_code;
   logic [1:0]  dll_freq;
   logic [3:0]  tap_sel;

   int n_checks = 0;
   int n_errs   = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [15:0] sh[7];

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_ctl_regbank uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cal_done(cal_done),
      .dll_ready(dll_ready), .pwr_on(pwr_on), .dll_en(dll_en), .drv_code(drv_code),
      .dll_freq(dll_freq), .tap_en(tap_en), .tap_sel(tap_sel), .strobe_pd(strobe_pd)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (exp_q.size() != 0) begin
         n_checks++; n_errs++;
         $display("FAIL R11: actual=%0d missing responses expected=0", exp_q.size());
      end
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   endtask

   // Monitor: pop one expected item per response
   always @(negedge clk) begin
      logic [31:0] e;
      string t;
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            n_checks++; n_errs++;
            $display("FAIL R11: actual=%h unexpected response expected=none", rsp_rdata);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, rsp_rdata, e);
         end
      end
   end

   function automatic logic [31:0] model_read(logic [7:0] a);
      if (a[1:0] == 2'b00 && a < 8'h1C) return {16'h0, sh[a >> 2]};
      if (a == 8'h20) return {25'h0, cal_done, dll_ready, 5'h0};
      return 32'h0;
   endfunction

   task automatic acc(bit wr, logic [7:0] a, logic [31:0] d, string t);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      exp_q.push_back(wr ? 32'h0 : model_read(a));
      tag_q.push_back(t);
      if (wr && a[1:0] == 2'b00 && a < 8'h1C)
         sh[a >> 2] = (sh[a >> 2] & ~d[31:16]) | (d[15:0] & d[31:16]);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic chk_outs(string t);
      chk({t, " R5 pwr_on"},   32'(pwr_on),    32'(sh[6][0]));
      chk({t, " R5 dll_en"},   32'(dll_en),    32'(sh[6][1]));
      chk({t, " R5 drv_code"}, 32'(drv_code),  32'(sh[6][6:4]));
      chk({t, " R6 dll_freq"}, 32'(dll_freq),  32'(sh[0][13:12]));
      chk({t, " R6 tap_en"},   32'(tap_en),    32'(sh[0][11]));
      chk({t, " R6 tap_sel"},  32'(tap_sel),   32'(sh[0][10:7]));
      chk({t, " R7 strobe"},   32'(strobe_pd), 32'(sh[2][9]));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
   end

   initial begin
      for (int k = 0; k < 7; k++) sh[k] = 16'h0;
      sh[0] = 16'h0200;
      repeat (3) @(negedge clk);
      chk_outs("R1 in reset");
      chk("R11 ready", 32'(req_ready), 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      chk_outs("R1 after reset");
      acc(0, 8'h00, 0, "R1 read 0x00");
      acc(0, 8'h18, 0, "R1 read 0x18");
      @(negedge clk);
      chk("R11 idle", 32'(rsp_valid), 32'h0);

      // R5: whole-field writes to 0x18
      acc(1, 8'h18, 32'h0073_0031, "R11 write rsp");
      chk_outs("R5 drv=3");
      // R2: single-bit mask, value all ones
      acc(1, 8'h18, 32'h0002_FFFF, "R11 write rsp");
      chk_outs("R2 dll_en only");
      acc(0, 8'h18, 0, "R4 read 0x18");
      // R3: zero mask
      acc(1, 8'h18, 32'h0000_FFFF, "R11 write rsp");
      chk_outs("R3 zero mask");
      acc(0, 8'h18, 0, "R3 read 0x18");
      acc(1, 8'h18, 32'h0070_0040, "R11 write rsp");
      chk_outs("R5 drv=4");

      // R6: main register fields, then tap_sel alone
      acc(1, 8'h00, 32'h3F80_2C80, "R11 write rsp");
      chk_outs("R6 fields");
      acc(1, 8'h00, 32'h0780_FFFF, "R11 write rsp");
      chk_outs("R2 tap_sel only");
      acc(0, 8'h00, 0, "R6 read 0x00");

      // R7: strobe pull-down on then off
      acc(1, 8'h08, 32'h0200_0200, "R11 write rsp");
      chk_outs("R7 on");
      acc(0, 8'h08, 0, "R7 read 0x08");
      acc(1, 8'h08, 32'h0200_0000, "R11 write rsp");
      chk_outs("R7 off");

      // R4: full mask write
      acc(1, 8'h04, 32'hFFFF_FFFF, "R11 write rsp");
      acc(0, 8'h04, 0, "R4 read 0x04 full");

      // R8: status patterns
      cal_done = 1'b1; dll_ready = 1'b0;
      acc(0, 8'h20, 0, "R8 cal only");
      cal_done = 1'b0; dll_ready = 1'b1;
      acc(0, 8'h20, 0, "R8 dll only");
      cal_done = 1'b1; dll_ready = 1'b1;
      acc(0, 8'h20, 0, "R8 both");

      // R9: write to status
      acc(1, 8'h20, 32'hFFFF_FFFF, "R11 write rsp");
      chk_outs("R9 status write");
      acc(0, 8'h00, 0, "R9 read 0x00");
      acc(0, 8'h18, 0, "R9 read 0x18");

      // R10: unmapped offsets
      acc(1, 8'h1C, 32'hFFFF_FFFF, "R11 write rsp");
      acc(1, 8'h01, 32'hFFFF_FFFF, "R11 write rsp");
      acc(1, 8'h24, 32'hFFFF_FFFF, "R11 write rsp");
      chk_outs("R10 unmapped write");
      acc(0, 8'h1C, 0, "R10 read 0x1C");
      acc(0, 8'h02, 0, "R10 read 0x02");
      acc(0, 8'h24, 0, "R10 read 0x24");
      for (int k = 0; k < 7; k++) acc(0, 8'(k * 4), 0, "R10 readback");

      repeat (2) @(negedge clk);
      chk("R11 idle end", 32'(rsp_valid), 32'h0);
      report();
   end
endmodule